// File: doc/BRIEF.md
# Attempt Lockout Counter

This block keeps count of wrong guesses against the two credentials of a secure memory: the mutual-authentication exchange and the password check. Each credential has its own 8-bit counter that starts at FF and, on every failed attempt, steps through a fixed chain of bit-clearing codes. It does not count down in binary. Two chains exist. The long one allows eight failures and the short one allows four, and a configuration pin picks which one is in use. A counter at 00 locks its credential. A counter holding a code that is not part of the active chain also locks it. While a credential is locked, its attempts are refused and no pass can be reported. A pass while the credential is unlocked puts the counter back to FF.

Three active-low configuration pins set the policy. `cfg_eight_n` picks the eight-failure chain when low. `cfg_unlim_n` lifts the lockout on the authentication credential when low. `cfg_cksum_n` allows unlimited checksum reads when low. The register that drives these pins holds 1 out of reset. A change on any of them takes effect on the next clock, with no re-initialisation. The block also raises a one-cycle `crypto_rst` pulse when the surrounding logic must drop its cipher state. That happens after a checksum read while checksum reads are limited, and after a MAC read while the authentication lockout is active.

Attempts, reads and configuration are plain level or strobe pins sampled on every clock. There is no back-pressure: an attempt strobe is always consumed in the cycle it is presented, and at most one attempt arrives per cycle.

Top module: `trial_guard`

## Requirements
- R1: After reset both counters read FF, neither locked flag is set, and `pass_ok`, `lock_rej` and `crypto_rst` are low.
- R2: With `cfg_eight_n`=0, each unlocked failure moves the selected counter one place along FF, FE, FC, F8, F0, E0, C0, 80, 00. The counter output changes one clock after the strobe.
- R3: With `cfg_eight_n`=1, each unlocked failure moves the selected counter one place along FF, EE, CC, 88, 00.
- R4: An attempt with `att_pass`=1 on an unlocked credential sets that counter to FF, and `pass_ok` is high for exactly the following cycle.
- R5: A counter at 00 sets its locked flag. Any attempt on a locked credential leaves its counter unchanged, raises `lock_rej` for the following cycle, and never raises `pass_ok`.
- R6: A counter value that is not a member of the chain selected by the present `cfg_eight_n` locks its credential. For example, FE is locked in four-failure mode and unlocked again when eight-failure mode returns.
- R7: With `cfg_unlim_n`=0, the authentication counter still steps on each failure and stays at 00 once there. `auth_locked` stays 0, and a pass is accepted even at 00.
- R8: `cfg_unlim_n` has no effect on the password counter or on `pw_locked`.
- R9: A `mac_read` strobe produces a one-cycle `crypto_rst` on the next cycle when `cfg_unlim_n`=1, and produces none when it is 0.
- R10: A `cks_read` strobe produces a one-cycle `crypto_rst` on the next cycle when `cfg_cksum_n`=1, and produces none when it is 0.
- R11: `att_pw`=0 selects the authentication counter and `att_pw`=1 selects the password counter. An attempt never changes the unselected counter.
- R12: On an authentication credential kept unlocked by R7 while holding a non-member code, a failure sets the counter to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_eight_n | input | 1 | Low: eight-failure chain; high: four-failure chain |
| cfg_unlim_n | input | 1 | Low: authentication never locks, no reset after MAC read |
| cfg_cksum_n | input | 1 | Low: unlimited checksum reads; high: reset after each |
| att_valid | input | 1 | Attempt result strobe |
| att_pass | input | 1 | Attempt outcome, 1 = correct |
| att_pw | input | 1 | Credential: 0 = authentication, 1 = password |
| cks_read | input | 1 | Checksum read completed |
| mac_read | input | 1 | MAC read in encryption mode completed |
| auth_cnt | output | 8 | Authentication attempts counter |
| pw_cnt | output | 8 | Password attempts counter |
| auth_locked | output | 1 | Authentication credential locked |
| pw_locked | output | 1 | Password credential locked |
| pass_ok | output | 1 | Previous-cycle attempt was accepted as a pass |
| lock_rej | output | 1 | Previous-cycle attempt was refused because of lock |
| crypto_rst | output | 1 | One-cycle request to clear cipher state |

## Verification
The bench drives both credentials to 00 and keeps failing them there. A design whose counter wraps or leaves 00 would unlock again on its own. It flips the chain selection while a counter sits on FE, so a design that checks membership only at the moment of failure would keep the credential unlocked. With the authentication override on, it pushes the counter past 00 and then presents a pass. A design that still honours the count would lock, or would refuse the pass. The bench also interleaves attempts on the two credentials and toggles each reset-source pin against its read strobe, which catches a design that lets the override reach the password counter or that ties the reset pulse to the wrong pin.

// File: rtl/trial_pkg.sv
package trial_pkg;
  localparam int CNT_W   = 8;
  localparam int HALF_W  = CNT_W / 2;
  localparam int NCRED   = 2;
  localparam int AUTH_IX = 0;
  localparam int PW_IX   = 1;

  // a mask of the form 1..10..0 (all ones above, all zeros below)
  function automatic logic is_high_run(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] inv;
    inv = ~v;
    return (inv & (inv + 1'b1)) == '0;
  endfunction

  function automatic logic half_high_run(input logic [HALF_W-1:0] v);
    logic [HALF_W-1:0] inv;
    inv = ~v;
    return (inv & (inv + 1'b1)) == '0;
  endfunction

  // membership of a code in the chain chosen by eight_n
  function automatic logic code_ok(input logic [CNT_W-1:0] c, input logic eight_n);
    logic [HALF_W-1:0] hi, lo;
    hi = c[CNT_W-1:HALF_W];
    lo = c[HALF_W-1:0];
    if (!eight_n) return is_high_run(c);
    return (hi == lo) && half_high_run(lo);
  endfunction

  // successor on a failure; any non-member collapses to zero
  function automatic logic [CNT_W-1:0] next_code(input logic [CNT_W-1:0] c, input logic eight_n);
    logic [HALF_W-1:0] hi, lo;
    hi = c[CNT_W-1:HALF_W];
    lo = c[HALF_W-1:0];
    if (!code_ok(c, eight_n)) return '0;
    if (!eight_n) return c << 1;
    return {hi << 1, lo << 1};
  endfunction
endpackage

// File: rtl/trial_counter.sv
module trial_counter
  import trial_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eight_n,
  input  logic             waive,
  input  logic             hit,
  input  logic             pass,
  output logic [CNT_W-1:0] cnt,
  output logic             locked,
  output logic             ok,
  output logic             rej
);
  logic raw_lock;

  assign raw_lock = (cnt == '0) || !code_ok(cnt, eight_n);
  assign locked   = raw_lock && !waive;
  assign ok       = hit && pass && !locked;
  assign rej      = hit && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
    end else if (hit && !locked) begin
      cnt <= pass ? '1 : next_code(cnt, eight_n);
    end
  end
endmodule

// File: rtl/crypto_reset_gen.sv
module crypto_reset_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cks_read,
  input  logic cks_limit_n,
  input  logic mac_read,
  input  logic unlim_n,
  output logic crypto_rst
);
  logic want;

  assign want = (cks_read && cks_limit_n) || (mac_read && unlim_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crypto_rst <= 1'b0;
    else        crypto_rst <= want;
  end
endmodule

// File: rtl/trial_guard.sv
module trial_guard
  import trial_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_eight_n,
  input  logic             cfg_unlim_n,
  input  logic             cfg_cksum_n,
  input  logic             att_valid,
  input  logic             att_pass,
  input  logic             att_pw,
  input  logic             cks_read,
  input  logic             mac_read,
  output logic [CNT_W-1:0] auth_cnt,
  output logic [CNT_W-1:0] pw_cnt,
  output logic             auth_locked,
  output logic             pw_locked,
  output logic             pass_ok,
  output logic             lock_rej,
  output logic             crypto_rst
);
  logic [CNT_W-1:0] cnt_v [NCRED];
  logic             lk_v  [NCRED];
  logic             ok_v  [NCRED];
  logic             rej_v [NCRED];
  logic             any_ok, any_rej;

  for (genvar g = 0; g < NCRED; g++) begin : g_cred
    localparam logic SEL_PW = (g == PW_IX);
    logic hit, waive;
    assign hit   = att_valid && (att_pw == SEL_PW);
    if (g == AUTH_IX) begin : g_waivable
      assign waive = !cfg_unlim_n;
    end else begin : g_strict
      assign waive = 1'b0;
    end
    trial_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .eight_n (cfg_eight_n),
      .waive   (waive),
      .hit     (hit),
      .pass    (att_pass),
      .cnt     (cnt_v[g]),
      .locked  (lk_v[g]),
      .ok      (ok_v[g]),
      .rej     (rej_v[g])
    );
  end

  always_comb begin
    any_ok  = 1'b0;
    any_rej = 1'b0;
    for (int i = 0; i < NCRED; i++) begin
      any_ok  = any_ok  | ok_v[i];
      any_rej = any_rej | rej_v[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_ok  <= 1'b0;
      lock_rej <= 1'b0;
    end else begin
      pass_ok  <= any_ok;
      lock_rej <= any_rej;
    end
  end

  crypto_reset_gen u_crst (
    .clk         (clk),
    .rst_n       (rst_n),
    .cks_read    (cks_read),
    .cks_limit_n (cfg_cksum_n),
    .mac_read    (mac_read),
    .unlim_n     (cfg_unlim_n),
    .crypto_rst  (crypto_rst)
  );

  assign auth_cnt    = cnt_v[AUTH_IX];
  assign pw_cnt      = cnt_v[PW_IX];
  assign auth_locked = lk_v[AUTH_IX];
  assign pw_locked   = lk_v[PW_IX];
endmodule

// File: rtl/trial_guard_chk.sv
module trial_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_eight_n,
  input logic       cfg_unlim_n,
  input logic       cfg_cksum_n,
  input logic       att_valid,
  input logic       att_pass,
  input logic       att_pw,
  input logic       cks_read,
  input logic       mac_read,
  input logic [7:0] auth_cnt,
  input logic [7:0] pw_cnt,
  input logic       auth_locked,
  input logic       pw_locked,
  input logic       pass_ok,
  input logic       lock_rej,
  input logic       crypto_rst
);
  AST_PW_EIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && att_pw && !att_pass && !pw_locked && !cfg_eight_n |=> pw_cnt == 8'(($past(pw_cnt) << 1))); // R2
  AST_PW_FOUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && att_pw && !att_pass && !pw_locked && cfg_eight_n |=> pw_cnt == (8'($past(pw_cnt) << 1) & 8'hEE)); // R3
  AST_AUTH_PASS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && !att_pw && att_pass && !auth_locked |=> auth_cnt == 8'hFF && pass_ok); // R4
  AST_ZERO_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pw_cnt == 8'h00 |-> pw_locked); // R5
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && att_pw && pw_locked |=> $stable(pw_cnt) && lock_rej && !pass_ok); // R5
  AST_UNLIM_NOLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlim_n |-> !auth_locked); // R7
  AST_MAC_RST: assert property (@(posedge clk) disable iff (!rst_n)
    mac_read && cfg_unlim_n |=> crypto_rst); // R9
  AST_CKS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cks_read && cfg_cksum_n |=> crypto_rst); // R10
  AST_RST_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    crypto_rst |-> $past((mac_read && cfg_unlim_n) || (cks_read && cfg_cksum_n))); // R9
  AST_OTHER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && att_pw |=> $stable(auth_cnt)); // R11
endmodule

bind trial_guard trial_guard_chk u_chk (.*);

// File: tb/sim_trial_guard.sv
`timescale 1ns/1ps
module sim_trial_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_eight_n = 1'b1, cfg_unlim_n = 1'b1, cfg_cksum_n = 1'b1;
  logic att_valid = 1'b0, att_pass = 1'b0, att_pw = 1'b0;
  logic cks_read = 1'b0, mac_read = 1'b0;
  logic [7:0] auth_cnt, pw_cnt;
  logic auth_locked, pw_locked, pass_ok, lock_rej, crypto_rst;

  always #2.5 clk = ~clk;

  trial_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_eight_n(cfg_eight_n), .cfg_unlim_n(cfg_unlim_n), .cfg_cksum_n(cfg_cksum_n),
    .att_valid(att_valid), .att_pass(att_pass), .att_pw(att_pw),
    .cks_read(cks_read), .mac_read(mac_read),
    .auth_cnt(auth_cnt), .pw_cnt(pw_cnt),
    .auth_locked(auth_locked), .pw_locked(pw_locked),
    .pass_ok(pass_ok), .lock_rej(lock_rej), .crypto_rst(crypto_rst)
  );

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  string req = "R1";

  // reference model state
  int m_cnt [2];
  bit m_ok, m_rej, m_crst;
  bit a_eight_n = 1, a_unlim_n = 1, a_cks_n = 1;   // configuration in effect
  bit t_eight_n = 1, t_unlim_n = 1, t_cks_n = 1;   // configuration to apply next

  function automatic int chain_pos(int c, bit eight_n);
    int four_l [5] = '{255, 238, 204, 136, 0};
    if (!eight_n) begin
      for (int i = 0; i <= 8; i++) if (((255 << i) & 255) == c) return i;
    end else begin
      for (int i = 0; i < 5; i++) if (four_l[i] == c) return i;
    end
    return -1;
  endfunction

  function automatic int chain_next(int c, bit eight_n);
    int p = chain_pos(c, eight_n);
    int four_l [5] = '{255, 238, 204, 136, 0};
    if (p < 0 || c == 0) return 0;
    if (!eight_n) return (255 << (p + 1)) & 255;
    return four_l[p + 1];
  endfunction

  function automatic bit m_locked(int ix, bit eight_n, bit unlim_n);
    bit raw = (m_cnt[ix] == 0) || (chain_pos(m_cnt[ix], eight_n) < 0);
    if (ix == 0) return raw && unlim_n;
    return raw;
  endfunction

  task automatic cmp(string what, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all();
    cmp("auth_cnt", int'(auth_cnt), m_cnt[0]);
    cmp("pw_cnt", int'(pw_cnt), m_cnt[1]);
    cmp("auth_locked", int'(auth_locked), int'(m_locked(0, a_eight_n, a_unlim_n)));
    cmp("pw_locked", int'(pw_locked), int'(m_locked(1, a_eight_n, a_unlim_n)));
    cmp("pass_ok", int'(pass_ok), int'(m_ok));
    cmp("lock_rej", int'(lock_rej), int'(m_rej));
    cmp("crypto_rst", int'(crypto_rst), int'(m_crst));
  endtask

  // one clock: check at falling edge, drive, advance model for the next rising edge
  task automatic cyc(bit v, bit p, bit pw, bit ck, bit mc);
    int ix;
    bit lk;
    @(negedge clk);
    check_all();
    a_eight_n = t_eight_n; a_unlim_n = t_unlim_n; a_cks_n = t_cks_n;
    cfg_eight_n = a_eight_n; cfg_unlim_n = a_unlim_n; cfg_cksum_n = a_cks_n;
    att_valid = v; att_pass = p; att_pw = pw; cks_read = ck; mac_read = mc;
    m_ok = 0; m_rej = 0;
    m_crst = (ck && a_cks_n) || (mc && a_unlim_n);
    if (v) begin
      ix = pw ? 1 : 0;
      lk = m_locked(ix, a_eight_n, a_unlim_n);
      if (lk) m_rej = 1;
      else if (p) begin m_cnt[ix] = 255; m_ok = 1; end
      else m_cnt[ix] = chain_next(m_cnt[ix], a_eight_n);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    att_valid = 0; cks_read = 0; mac_read = 0;
    m_cnt[0] = 255; m_cnt[1] = 255; m_ok = 0; m_rej = 0; m_crst = 0;
    @(negedge clk);
    req = "R1";
    check_all();
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 50000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(0, 0, 0, 0, 0);

    // R2: eight-failure chain on the password counter, then past zero
    req = "R2"; t_eight_n = 0;
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 0, 0);
    req = "R5";
    cyc(1, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R3: four-failure chain on the authentication counter
    do_reset(); req = "R3"; t_eight_n = 1;
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    req = "R5";
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R4: pass after some failures restores FF
    do_reset(); req = "R4";
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R6: FE is a member only of the eight chain
    do_reset(); req = "R6"; t_eight_n = 0;
    cyc(1, 0, 1, 0, 0);
    t_eight_n = 1;
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0);
    t_eight_n = 0;
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R7: unlimited override on authentication
    do_reset(); req = "R7"; t_eight_n = 1; t_unlim_n = 0;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R8: override leaves the password counter alone
    req = "R8";
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R12: waived non-member code collapses to zero on failure
    do_reset(); req = "R12"; t_eight_n = 0; t_unlim_n = 1;
    cyc(1, 0, 0, 0, 0);
    t_eight_n = 1; t_unlim_n = 0;
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R9: MAC read reset gated by the override
    do_reset(); req = "R9"; t_unlim_n = 1;
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    t_unlim_n = 0;
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);

    // R10: checksum read reset gated by its own pin
    req = "R10"; t_unlim_n = 1; t_cks_n = 1;
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    t_cks_n = 0;
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    t_cks_n = 1;

    // R11: interleaved credentials
    do_reset(); req = "R11"; t_eight_n = 0;
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule